// File: doc/BRIEF.md
# Byte-lane DDR complex-sample transmitter

This block feeds a high-speed DAC that takes two complex channels over one 16-bit double-data-rate bus. Each channel supplies a 16-bit I word and a 16-bit Q word per sample. The block splits each word into bytes and places each channel on its own byte lane. Within one sample period it sends four bytes per lane, one on every edge of the forwarded data clock. The DDR output is modelled as two single-rate byte streams, one for rising edges and one for falling edges, so that the physical output cells can sit outside this block.

One sample period spans two cycles of the data clock. The block paces its source with a take strobe. It also produces two control strobes. The first marks byte phase for the converter's input FIFO. The second aligns the converter's FIFO read side and its mixer and oscillator state. That second strobe runs either as a held one-shot pulse or as a periodic pulse whose period is a multiple of 16 data-clock cycles.

Top module: `iq_ddr_tx`

## Requirements
- R1: Bits [15:8] of both byte outputs carry channel A (ab_i/ab_q) and bits [7:0] carry channel B (cd_i/cd_q).
- R2: After reset, `take_o` is high on alternate cycles, starting with the first cycle after reset is released. The four input words are captured at the clock edge that ends a cycle with `take_o` high.
- R3: In the cycle after a capture edge (the I cycle), `rise_byte` carries the I high byte and `fall_byte` carries the I low byte. In the next cycle (the Q cycle) they carry the Q high and Q low bytes of the same captured sample, with no skew between I and Q.
- R4: While `rst_n` is low, both byte outputs are zero, `frame_o` and `sync_o` are low, and `take_o` is high.
- R5: A pulse on `frame_req` yields exactly one `frame_o` cycle, and that cycle is always an I cycle. A request seen at a capture edge fires at once. Any other request waits for the next capture edge.
- R6: With `sync_periodic` low, a `sync_req` pulse drives `sync_o` high for exactly SYNC_HOLD consecutive cycles, starting on an I cycle.
- R7: A one-shot request that arrives while a one-shot pulse is high is held. It fires on the first I cycle after the current pulse has dropped, so the pulse starts SYNC_HOLD+2 cycles (even SYNC_HOLD) or SYNC_HOLD+1 cycles (odd SYNC_HOLD) after the start of the first pulse.
- R8: With `sync_periodic` high, `sync_o` is high for SYNC_HOLD cycles out of every 16*SYNC_MULT cycles. One-shot requests made in that mode are discarded and produce no pulse later.
- R9: The first periodic pulse begins in the cycle right after the first edge that samples `sync_periodic` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock (one rise and one fall slot per cycle) |
| rst_n | input | 1 | Active-low synchronous reset |
| ab_i | input | 16 | Channel A in-phase word |
| ab_q | input | 16 | Channel A quadrature word |
| cd_i | input | 16 | Channel B in-phase word |
| cd_q | input | 16 | Channel B quadrature word |
| frame_req | input | 1 | Request one byte-phase marker |
| sync_req | input | 1 | Request one held alignment pulse |
| sync_periodic | input | 1 | Selects periodic alignment pulses |
| take_o | output | 1 | Inputs are captured at the end of this cycle |
| rise_byte | output | 16 | Bytes for the rising-edge slot |
| fall_byte | output | 16 | Bytes for the falling-edge slot |
| frame_o | output | 1 | Byte-phase marker, high for one I cycle |
| sync_o | output | 1 | Alignment strobe |

## Verification
The assertions check on every cycle that the Q bytes on each lane come from the same capture as the I bytes that came just before them. They also check that the frame marker is a single cycle on an I slot, that every one-shot pulse lasts exactly the hold length, and that periodic rises are exactly one period apart. Only the bench scenarios can show the lane assignment and full word rebuild over a sweep of byte values, the effect of where a request lands relative to the sample phase, the deferral of a request made during a pulse, and that one-shot requests made in periodic mode are dropped.

// File: rtl/iqtx_pkg.sv
package iqtx_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = WORD_W / 2;
  localparam int LANES  = 2;

  function automatic logic [BYTE_W-1:0] byte_hi(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] byte_lo(input logic [WORD_W-1:0] w);
    return w[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/iqtx_pacer.sv
module iqtx_pacer (
  input  logic clk,
  input  logic rst_n,
  output logic take,
  output logic q_slot
);
  logic phase;

  // phase 0: cycle ends with a capture edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= 1'b0;
      q_slot <= 1'b0;
    end else begin
      phase  <= ~phase;
      q_slot <= phase;
    end
  end

  assign take = ~phase;
endmodule

// File: rtl/iqtx_lane.sv
module iqtx_lane
  import iqtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WORD_W-1:0] i_in,
  input  logic [WORD_W-1:0] q_in,
  output logic [BYTE_W-1:0] rise_o,
  output logic [BYTE_W-1:0] fall_o
);
  logic [WORD_W-1:0] q_hold;
  logic              armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_hold <= '0;
      rise_o <= '0;
      fall_o <= '0;
      armed  <= 1'b0;
    end else if (take) begin
      q_hold <= q_in;
      rise_o <= byte_hi(i_in);
      fall_o <= byte_lo(i_in);
      armed  <= 1'b1;
    end else begin
      rise_o <= byte_hi(q_hold);
      fall_o <= byte_lo(q_hold);
    end
  end

  // R3: Q bytes belong to the same capture as the preceding I bytes
  a_r3_q_matches_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !take) |=> (rise_o == byte_hi($past(q_in, 2)) && fall_o == byte_lo($past(q_in, 2))));
endmodule

// File: rtl/iqtx_strobes.sv
module iqtx_strobes #(
  parameter int SYNC_HOLD = 4,
  parameter int SYNC_MULT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic frame_req,
  input  logic sync_req,
  input  logic periodic,
  output logic frame_o,
  output logic sync_o
);
  localparam int PERIOD = 16 * SYNC_MULT;
  localparam int HC_W   = $clog2(SYNC_HOLD + 1) + 1;
  localparam int PC_W   = $clog2(PERIOD + 1) + 1;

  logic            frame_pend, sync_pend, sync_os, sync_per;
  logic [HC_W-1:0] os_cnt;
  logic [PC_W-1:0] per_cnt;
  logic            frame_fire, sync_start;

  assign frame_fire = take & (frame_pend | frame_req);
  assign sync_start = take & (sync_pend | sync_req) & ~sync_os & ~periodic;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_o    <= 1'b0;
      frame_pend <= 1'b0;
      sync_pend  <= 1'b0;
      sync_os    <= 1'b0;
      os_cnt     <= '0;
      sync_per   <= 1'b0;
      per_cnt    <= '0;
    end else begin
      frame_o    <= frame_fire;
      frame_pend <= (frame_pend | frame_req) & ~frame_fire;
      sync_pend  <= periodic ? 1'b0 : ((sync_pend | sync_req) & ~sync_start);
      if (sync_start) begin
        sync_os <= 1'b1;
        os_cnt  <= HC_W'(SYNC_HOLD - 1);
      end else if (os_cnt != '0) begin
        os_cnt  <= os_cnt - 1'b1;
      end else begin
        sync_os <= 1'b0;
      end
      sync_per <= periodic && (per_cnt < PC_W'(SYNC_HOLD));
      if (!periodic || per_cnt == PC_W'(PERIOD - 1)) per_cnt <= '0;
      else per_cnt <= per_cnt + 1'b1;
    end
  end

  assign sync_o = sync_os | sync_per;

  // observation counters for the checks below
  logic            per_d, per_seen;
  logic [HC_W-1:0] hi_cnt;
  logic [PC_W-1:0] gap;
  logic            per_rose;
  assign per_rose = sync_per & ~per_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_d <= 1'b0; per_seen <= 1'b0; hi_cnt <= '0; gap <= '0;
    end else begin
      per_d    <= sync_per;
      per_seen <= periodic & (per_seen | per_rose);
      hi_cnt   <= !sync_os ? '0 : (&hi_cnt ? hi_cnt : hi_cnt + 1'b1);
      gap      <= per_rose ? PC_W'(1) : (&gap ? gap : gap + 1'b1);
    end
  end

  // R5: marker lasts a single cycle
  a_r5_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |=> !frame_o);
  // R6: one-shot pulse width
  a_r6_hold_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_os) |-> hi_cnt == HC_W'(SYNC_HOLD));
  // R8: periodic rises are one period apart
  a_r8_period: assert property (@(posedge clk) disable iff (!rst_n)
    (per_rose && per_seen && periodic) |-> gap == PC_W'(PERIOD));
endmodule

// File: rtl/iq_ddr_tx.sv
module iq_ddr_tx
  import iqtx_pkg::*;
#(
  parameter int SYNC_HOLD = 4,
  parameter int SYNC_MULT = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] ab_i,
  input  logic [15:0] ab_q,
  input  logic [15:0] cd_i,
  input  logic [15:0] cd_q,
  input  logic        frame_req,
  input  logic        sync_req,
  input  logic        sync_periodic,
  output logic        take_o,
  output logic [15:0] rise_byte,
  output logic [15:0] fall_byte,
  output logic        frame_o,
  output logic        sync_o
);
  logic                          take, q_slot;
  logic [LANES-1:0][WORD_W-1:0] i_words, q_words;
  logic [LANES-1:0][BYTE_W-1:0] rise_l, fall_l;

  // lane 1 is the upper byte lane (channel A)
  assign i_words = {ab_i, cd_i};
  assign q_words = {ab_q, cd_q};

  iqtx_pacer u_pacer (.clk(clk), .rst_n(rst_n), .take(take), .q_slot(q_slot));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    iqtx_lane u_lane (
      .clk(clk), .rst_n(rst_n), .take(take),
      .i_in(i_words[l]), .q_in(q_words[l]),
      .rise_o(rise_l[l]), .fall_o(fall_l[l])
    );
  end

  iqtx_strobes #(.SYNC_HOLD(SYNC_HOLD), .SYNC_MULT(SYNC_MULT)) u_strobes (
    .clk(clk), .rst_n(rst_n), .take(take),
    .frame_req(frame_req), .sync_req(sync_req), .periodic(sync_periodic),
    .frame_o(frame_o), .sync_o(sync_o)
  );

  assign take_o    = take;
  assign rise_byte = rise_l;
  assign fall_byte = fall_l;

  // R5: marker only on an I cycle
  a_r5_frame_on_i: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |-> !q_slot);
  // R2: capture cycles alternate
  a_r2_take_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
endmodule

// File: tb/test_iq_ddr_tx.sv
module test_iq_ddr_tx;
  localparam int HOLD = 4;
  localparam int PER  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] ab_i = '0, ab_q = '0, cd_i = '0, cd_q = '0;
  logic frame_req = 1'b0, sync_req = 1'b0, sync_periodic = 1'b0;
  logic take_o, frame_o, sync_o;
  logic [15:0] rise_byte, fall_byte;

  iq_ddr_tx #(.SYNC_HOLD(HOLD), .SYNC_MULT(1)) i_iq_ddr_tx (
    .clk(clk), .rst_n(rst_n), .ab_i(ab_i), .ab_q(ab_q), .cd_i(cd_i), .cd_q(cd_q),
    .frame_req(frame_req), .sync_req(sync_req), .sync_periodic(sync_periodic),
    .take_o(take_o), .rise_byte(rise_byte), .fall_byte(fall_byte),
    .frame_o(frame_o), .sync_o(sync_o)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0, run = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor state
  int cyc = 0, bp = 1, fcount = 0, rise_count = 0, last_rise = -1, prev_rise = -1;
  int last_width = 0, w = 0;
  bit sp = 0, last_rise_i = 0;
  logic [7:0]  k = 8'd0;
  logic [15:0] s_ab_i = '0, s_ab_q = '0, s_cd_i = '0, s_cd_q = '0;

  always @(negedge clk) begin
    if (run) begin
      cyc = cyc + 1;
      if (bp == 1) begin
        chk(take_o == 1'b0, "R2 take", take_o, 0);
        chk({rise_byte[15:8], fall_byte[15:8]} == s_ab_i, "R1 R3 lane A I", {rise_byte[15:8], fall_byte[15:8]}, s_ab_i);
        chk({rise_byte[7:0], fall_byte[7:0]} == s_cd_i, "R1 R3 lane B I", {rise_byte[7:0], fall_byte[7:0]}, s_cd_i);
      end else begin
        chk(take_o == 1'b1, "R2 take", take_o, 1);
        chk({rise_byte[15:8], fall_byte[15:8]} == s_ab_q, "R1 R3 lane A Q", {rise_byte[15:8], fall_byte[15:8]}, s_ab_q);
        chk({rise_byte[7:0], fall_byte[7:0]} == s_cd_q, "R1 R3 lane B Q", {rise_byte[7:0], fall_byte[7:0]}, s_cd_q);
        k = k + 8'd1;
        s_ab_i = {k, k ^ 8'hFF};
        s_ab_q = {k + 8'd1, k ^ 8'h3C};
        s_cd_i = {k ^ 8'hA5, k + 8'd17};
        s_cd_q = {8'(k * 8'd3), ~k};
        ab_i = s_ab_i; ab_q = s_ab_q; cd_i = s_cd_i; cd_q = s_cd_q;
      end
      if (frame_o) begin
        fcount++;
        chk(bp == 1, "R5 frame on I cycle", bp, 1);
      end
      if (sync_o && !sp) begin
        prev_rise = last_rise; last_rise = cyc; rise_count++; last_rise_i = (bp == 1);
      end
      if (sync_o) w++;
      else if (sp) begin last_width = w; w = 0; end
      sp = sync_o;
      bp = 1 - bp;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_take;
    do wait_cyc(1); while (bp != 1); // cycle just begun at the negedge was a capture cycle
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r0, f0, c, r1;
    // R4 reset state
    wait_cyc(3);
    chk(rise_byte == 16'h0 && fall_byte == 16'h0, "R4 bytes in reset", {rise_byte, fall_byte}, 0);
    chk(frame_o == 1'b0 && sync_o == 1'b0, "R4 strobes in reset", {frame_o, sync_o}, 0);
    chk(take_o == 1'b1, "R4 take in reset", take_o, 1);
    rst_n = 1'b1; run = 1'b1;
    // R1 R2 R3 sweep over all byte values
    wait_cyc(560);

    // R5 request at a capture cycle and at the other cycle
    wait_take();
    f0 = fcount; frame_req = 1; wait_cyc(1); frame_req = 0; wait_cyc(8);
    chk(fcount - f0 == 1, "R5 frame count aligned", fcount - f0, 1);
    wait_take(); wait_cyc(1);
    f0 = fcount; frame_req = 1; wait_cyc(1); frame_req = 0; wait_cyc(8);
    chk(fcount - f0 == 1, "R5 frame count deferred", fcount - f0, 1);

    // R6 one-shot width and alignment
    wait_take();
    r0 = rise_count; sync_req = 1; wait_cyc(1); sync_req = 0; wait_cyc(12);
    chk(rise_count - r0 == 1, "R6 one pulse", rise_count - r0, 1);
    chk(last_width == HOLD, "R6 width", last_width, HOLD);
    chk(last_rise_i, "R6 starts on I cycle", last_rise_i, 1);

    // R7 request during an active pulse
    wait_take();
    r0 = rise_count; sync_req = 1; wait_cyc(1); sync_req = 0;
    r1 = cyc; // first pulse began in this cycle
    sync_req = 1; wait_cyc(1); sync_req = 0; wait_cyc(20);
    chk(rise_count - r0 == 2, "R7 two pulses", rise_count - r0, 2);
    chk(last_rise - prev_rise == HOLD + ((HOLD % 2 == 0) ? 2 : 1), "R7 deferred start",
        last_rise - prev_rise, HOLD + ((HOLD % 2 == 0) ? 2 : 1));
    chk(prev_rise == r1, "R7 first pulse start", prev_rise, r1);
    chk(last_width == HOLD, "R7 width", last_width, HOLD);

    // R9 R8 periodic mode
    wait_cyc(3);
    c = cyc; sync_periodic = 1; wait_cyc(1);
    chk(sync_o == 1'b1 && last_rise == c + 1, "R9 first periodic pulse", last_rise, c + 1);
    wait_cyc(18);
    sync_req = 1; wait_cyc(1); sync_req = 0;
    wait_cyc(c + 40 - cyc);
    chk(last_rise - prev_rise == PER, "R8 period", last_rise - prev_rise, PER);
    chk(last_width == HOLD, "R8 width", last_width, HOLD);
    chk(last_rise == c + 33, "R8 third rise", last_rise, c + 33);
    r0 = rise_count; sync_periodic = 0; wait_cyc(30);
    chk(rise_count == r0, "R8 request discarded", rise_count - r0, 0);
    chk(sync_o == 1'b0, "R8 idle after periodic", sync_o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule